// File: doc/BRIEF.md
# Interleaved Two-Bank Tightly-Coupled Memory Arbiter

This block sits between three requesters and a tightly-coupled memory made of two banks that are interleaved on 64-bit doublewords. The requesters are a load-store port, an instruction-fetch port and a DMA port. Each presents a request with an address, a write flag, 64-bit write data and byte enables. Each bank gets its own arbitration, so two requesters that target different banks are served in the same cycle. Requesters that target the same bank are served in priority order: load-store first, then DMA, then fetch.

Write data leaves the block with one parity bit per byte. A static input picks even or odd parity. Returning read data is checked against its stored parity. A mismatch, or an error signalled by the bank itself, is reported to the requester that owned the access. A bank that raises its wait input keeps its current owner until the wait drops. Reads have no side effects, so a requester may issue them speculatively.

Top module: `tcm_ilv_arb`

## Requirements
- R1: Address bit 3 selects the bank (0 or 1). The bank row index is address bits [AW-1:4]. Requester addresses are doubleword aligned, so bits [2:0] are zero.
- R2: When the load-store port (requester 0) and another requester target the same bank, and that bank is not held, the load-store port is granted.
- R3: When DMA (requester 2) and fetch (requester 1) target the same free bank without load-store, DMA is granted and fetch is stalled.
- R4: Requesters on different banks are granted in the same cycle. Two sequential doubleword streams from load-store and DMA that start on the same bank stall DMA exactly once. After that the streams run on opposite banks with no further stall.
- R5: While a bank's wait input is high, its current owner keeps the grant and sees a stall. No other requester is granted that bank until the wait drops.
- R6: A requester's stall output is high in any cycle where its request is present but its access does not complete (not granted, or granted under wait).
- R7: One cycle after an access completes, the owner alone sees done high. For a read, that cycle also carries the bank's read data.
- R8: Each written byte i carries parity bit i. With the parity-select input at 0 the bit is the XOR of the byte (even). With the input at 1 it is the complement (odd).
- R9: Byte enables are forwarded to the bank. Only enabled bytes and their parity bits change in memory.
- R10: In the done cycle of a read, the error output is high when any byte's returned parity disagrees with the selected sense.
- R11: A bank error input that is high in the done cycle is reported on the owner's error output, for reads and writes alike.
- R12: Out of reset, with no requests, there are no grants, bank enables, done or error outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_odd_par | input | 1 | Parity sense: 0 even, 1 odd (static) |
| rq_req | input | 3 | Request per requester (0 load-store, 1 fetch, 2 DMA) |
| rq_addr | input | 3x16 | Byte address per requester |
| rq_we | input | 3 | Write flag per requester |
| rq_wdata | input | 3x64 | Write data per requester |
| rq_be | input | 3x8 | Byte enables per requester |
| rq_gnt | output | 3 | Requester owns a bank this cycle |
| rq_stall | output | 3 | Request present but not completing |
| rq_done | output | 3 | Access completed last cycle |
| rq_rdata | output | 3x64 | Read data, valid with done |
| rq_err | output | 3 | Parity or bank error, valid with done |
| bk_en | output | 2 | Bank access enable |
| bk_we | output | 2 | Bank write flag |
| bk_idx | output | 2x12 | Bank row index |
| bk_wdata | output | 2x64 | Bank write data |
| bk_be | output | 2x8 | Bank byte enables |
| bk_wpar | output | 2x8 | Bank write parity, one bit per byte |
| bk_rdata | input | 2x64 | Bank read data, one cycle after access |
| bk_rpar | input | 2x8 | Stored parity returned with read data |
| bk_wait | input | 2 | Bank cannot complete the current access |
| bk_err | input | 2 | Bank error, sampled in the done cycle |

## Verification
The grant, stall and bank-side outputs are combinational from the requests in the same cycle. The bench drives each request on the falling edge and reads those outputs one nanosecond later, before the next rising edge. Done, read data and error come from a register, so they are due in the cycle after the completing edge. The bench samples them at the next falling edge. Wait cases are stepped one falling edge at a time, so grant ownership is checked in every held cycle. The interleaved-stream case counts stalls cycle by cycle against a five-cycle schedule.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

    localparam int NREQ    = 3;
    localparam int NBANK   = 2;
    localparam int DW      = 64;
    localparam int NBYTE   = DW / 8;
    localparam int SEL_BIT = $clog2(NBYTE);

    typedef enum logic [1:0] {
        PORT_LS  = 2'd0,
        PORT_IF  = 2'd1,
        PORT_DMA = 2'd2
    } port_e;

    // index 0 is the highest priority
    localparam port_e PRIO_ORDER [NREQ] = '{PORT_LS, PORT_DMA, PORT_IF};

    typedef struct packed {
        logic  vld;
        logic  wr;
        port_e own;
    } rsp_t;

    function automatic logic [NBYTE-1:0] byte_par(input logic [DW-1:0] d,
                                                  input logic          odd);
        logic [NBYTE-1:0] p;
        for (int i = 0; i < NBYTE; i++) p[i] = (^d[8*i +: 8]) ^ odd;
        return p;
    endfunction

endpackage

// File: rtl/dbt_parity.sv
module dbt_parity
    import dbt_pkg::*;
(
    input  logic             odd,
    input  logic [DW-1:0]    wdata,
    output logic [NBYTE-1:0] wpar,
    input  logic [DW-1:0]    rdata,
    input  logic [NBYTE-1:0] rpar,
    output logic             mismatch
);
    logic [NBYTE-1:0] lane_bad;

    for (genvar g = 0; g < NBYTE; g++) begin : g_lane
        assign wpar[g]     = (^wdata[8*g +: 8]) ^ odd;
        assign lane_bad[g] = ((^rdata[8*g +: 8]) ^ odd) != rpar[g];
    end

    assign mismatch = |lane_bad;
endmodule

// File: rtl/dbt_bank_arb.sv
module dbt_bank_arb
    import dbt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NREQ-1:0] hit,
    input  logic [NREQ-1:0] wr,
    input  logic            bank_wait,
    output logic            en,
    output logic [NREQ-1:0] gnt,
    output port_e           own,
    output rsp_t            rsp
);
    logic  lock_q;
    port_e lock_own_q;
    port_e pick;
    logic  any;

    always_comb begin
        pick = PORT_LS;
        any  = 1'b0;
        for (int k = NREQ - 1; k >= 0; k--) begin
            if (hit[PRIO_ORDER[k]]) begin
                pick = PRIO_ORDER[k];
                any  = 1'b1;
            end
        end
        if (lock_q) begin
            pick = lock_own_q;
            any  = hit[lock_own_q];
        end
    end

    assign en  = any;
    assign own = pick;
    assign gnt = any ? (NREQ'(1) << pick) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q     <= 1'b0;
            lock_own_q <= PORT_LS;
            rsp        <= '0;
        end else begin
            lock_q     <= any & bank_wait;
            lock_own_q <= pick;
            rsp.vld    <= any & ~bank_wait;
            rsp.wr     <= wr[pick];
            rsp.own    <= pick;
        end
    end

    AST_LS_FIRST: assert property (@(posedge clk) disable iff (rst)
        (hit[PORT_LS] && !lock_q) |-> gnt[PORT_LS]); // R2

    AST_DMA_OVER_IF: assert property (@(posedge clk) disable iff (rst)
        (hit[PORT_DMA] && !hit[PORT_LS] && !lock_q) |-> !gnt[PORT_IF]); // R3

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && bank_wait) |=> (!en || $stable(gnt))); // R5

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        rsp.vld |-> $past(en && !bank_wait)); // R7
endmodule

// File: rtl/tcm_ilv_arb.sv
module tcm_ilv_arb
    import dbt_pkg::*;
#(
    parameter int AW = 16,
    localparam int IW = AW - SEL_BIT - 1
)(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cfg_odd_par,
    input  logic [NREQ-1:0]                  rq_req,
    input  logic [NREQ-1:0][AW-1:0]          rq_addr,
    input  logic [NREQ-1:0]                  rq_we,
    input  logic [NREQ-1:0][DW-1:0]          rq_wdata,
    input  logic [NREQ-1:0][NBYTE-1:0]       rq_be,
    output logic [NREQ-1:0]                  rq_gnt,
    output logic [NREQ-1:0]                  rq_stall,
    output logic [NREQ-1:0]                  rq_done,
    output logic [NREQ-1:0][DW-1:0]          rq_rdata,
    output logic [NREQ-1:0]                  rq_err,
    output logic [NBANK-1:0]                 bk_en,
    output logic [NBANK-1:0]                 bk_we,
    output logic [NBANK-1:0][IW-1:0]         bk_idx,
    output logic [NBANK-1:0][DW-1:0]         bk_wdata,
    output logic [NBANK-1:0][NBYTE-1:0]      bk_be,
    output logic [NBANK-1:0][NBYTE-1:0]      bk_wpar,
    input  logic [NBANK-1:0][DW-1:0]         bk_rdata,
    input  logic [NBANK-1:0][NBYTE-1:0]      bk_rpar,
    input  logic [NBANK-1:0]                 bk_wait,
    input  logic [NBANK-1:0]                 bk_err
);
    logic [NBANK-1:0][NREQ-1:0] hit;
    logic [NBANK-1:0][NREQ-1:0] gnt_b;
    port_e                      own   [NBANK];
    rsp_t                       rsp   [NBANK];
    logic [NBANK-1:0]           perr;

    for (genvar r = 0; r < NREQ; r++) begin : g_req
        logic sel;
        assign sel = rq_addr[r][SEL_BIT];
        for (genvar b = 0; b < NBANK; b++) begin : g_hit
            assign hit[b][r] = rq_req[r] & (sel == 1'(b));
        end
        assign rq_gnt[r]   = gnt_b[0][r] | gnt_b[1][r];
        assign rq_stall[r] = rq_req[r] & ~(gnt_b[sel][r] & ~bk_wait[sel]);

        AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
            rq_req[r] |-> (rq_addr[r][SEL_BIT-1:0] == '0)); // R1
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        dbt_bank_arb u_arb (
            .clk       (clk),
            .rst       (rst),
            .hit       (hit[b]),
            .wr        (rq_we),
            .bank_wait (bk_wait[b]),
            .en        (bk_en[b]),
            .gnt       (gnt_b[b]),
            .own       (own[b]),
            .rsp       (rsp[b])
        );

        assign bk_we[b]    = rq_we[own[b]];
        assign bk_idx[b]   = rq_addr[own[b]][AW-1:SEL_BIT+1];
        assign bk_wdata[b] = rq_wdata[own[b]];
        assign bk_be[b]    = rq_be[own[b]];

        dbt_parity u_par (
            .odd      (cfg_odd_par),
            .wdata    (bk_wdata[b]),
            .wpar     (bk_wpar[b]),
            .rdata    (bk_rdata[b]),
            .rpar     (bk_rpar[b]),
            .mismatch (perr[b])
        );
    end

    always_comb begin
        rq_done  = '0;
        rq_err   = '0;
        rq_rdata = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (rsp[b].vld) begin
                rq_done[rsp[b].own]  = 1'b1;
                rq_rdata[rsp[b].own] = bk_rdata[b];
                rq_err[rsp[b].own]   = bk_err[b] | (~rsp[b].wr & perr[b]);
            end
        end
    end

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        ((rq_err & ~rq_done) == '0)); // R10

    AST_BANKS_SPLIT: assert property (@(posedge clk) disable iff (rst)
        ((gnt_b[0] & gnt_b[1]) == '0)); // R1
endmodule

// File: tb/tcm_ilv_arb_bench.sv
`timescale 1ns/1ps
module tcm_ilv_arb_bench;
    import dbt_pkg::*;

    localparam int AW = 16;
    localparam int IW = AW - SEL_BIT - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic                       cfg_odd_par = 1'b0;
    logic [2:0]                 req = '0;
    logic [2:0][AW-1:0]         addr = '0;
    logic [2:0]                 we = '0;
    logic [2:0][63:0]           wdata = '0;
    logic [2:0][7:0]            be = '0;
    logic [2:0]                 rq_gnt, rq_stall, rq_done, rq_err;
    logic [2:0][63:0]           rq_rdata;
    logic [1:0]                 bk_en, bk_we;
    logic [1:0][IW-1:0]         bk_idx;
    logic [1:0][63:0]           bk_wdata;
    logic [1:0][7:0]            bk_be, bk_wpar;
    logic [1:0][63:0]           rd_q;
    logic [1:0][7:0]            rp_q;
    logic [1:0]                 wt = '0;
    logic [1:0]                 err_arm = '0;
    logic [1:0]                 err_q;
    logic [1:0][7:0]            flip = '0;

    int total = 0;
    int bad   = 0;

    tcm_ilv_arb u_tcm_ilv_arb (
        .clk(clk), .rst(rst), .cfg_odd_par(cfg_odd_par),
        .rq_req(req), .rq_addr(addr), .rq_we(we), .rq_wdata(wdata), .rq_be(be),
        .rq_gnt(rq_gnt), .rq_stall(rq_stall), .rq_done(rq_done),
        .rq_rdata(rq_rdata), .rq_err(rq_err),
        .bk_en(bk_en), .bk_we(bk_we), .bk_idx(bk_idx), .bk_wdata(bk_wdata),
        .bk_be(bk_be), .bk_wpar(bk_wpar), .bk_rdata(rd_q), .bk_rpar(rp_q),
        .bk_wait(wt), .bk_err(err_q)
    );

    // bank memory model: one-cycle read latency, byte-enabled writes
    logic [63:0] mem [2][16];
    logic [7:0]  pm  [2][16];
    always @(posedge clk) begin
        for (int b = 0; b < 2; b++) begin
            if (bk_en[b] && !wt[b]) begin
                if (bk_we[b]) begin
                    for (int i = 0; i < 8; i++) begin
                        if (bk_be[b][i]) begin
                            mem[b][bk_idx[b][3:0]][8*i +: 8] <= bk_wdata[b][8*i +: 8];
                            pm[b][bk_idx[b][3:0]][i]         <= bk_wpar[b][i];
                        end
                    end
                end
                rd_q[b]  <= mem[b][bk_idx[b][3:0]];
                rp_q[b]  <= pm[b][bk_idx[b][3:0]] ^ flip[b];
                err_q[b] <= err_arm[b];
            end else begin
                err_q[b] <= 1'b0;
            end
        end
    end

    function automatic logic [7:0] exp_par(input logic [63:0] d, input logic odd);
        logic [7:0] p;
        for (int i = 0; i < 8; i++) p[i] = ($countones(d[8*i +: 8]) % 2 == 1) ^ odd;
        return p;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drop_all();
        req = '0;
        we  = '0;
    endtask

    // one access on requester r; returns response sampled in the done cycle
    task automatic xfer(input int r, input logic [AW-1:0] a, input logic w,
                        input logic [63:0] d, input logic [7:0] m,
                        output logic [63:0] rdat, output logic er, output logic dn);
        @(negedge clk);
        req[r] = 1'b1; addr[r] = a; we[r] = w; wdata[r] = d; be[r] = m;
        forever begin
            #1;
            if (!rq_stall[r]) break;
            @(negedge clk);
        end
        @(negedge clk);
        req[r] = 1'b0; we[r] = 1'b0;
        rdat = rq_rdata[r];
        er   = rq_err[r];
        dn   = rq_done[r];
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R12 gnt", 64'(rq_gnt), 64'h0);
        check("R12 bk_en", 64'(bk_en), 64'h0);
        check("R12 done", 64'(rq_done), 64'h0);
        check("R12 err", 64'(rq_err), 64'h0);
    endtask

    task automatic t_bank_sel();
        @(negedge clk);
        req[0] = 1'b1; addr[0] = 16'h0018; we[0] = 1'b0; be[0] = 8'hFF;
        #1;
        check("R1 bank1 enable", 64'(bk_en), 64'h2);
        check("R1 bank1 index", 64'(bk_idx[1]), 64'h1);
        @(negedge clk);
        addr[0] = 16'h0020;
        #1;
        check("R1 bank0 enable", 64'(bk_en), 64'h1);
        check("R1 bank0 index", 64'(bk_idx[0]), 64'h2);
        @(negedge clk);
        drop_all();
    endtask

    task automatic t_rw_parity();
        logic [63:0] rd; logic er, dn;
        logic [63:0] d;
        d = 64'h0103_0700_FF80_1234;
        cfg_odd_par = 1'b0;
        @(negedge clk);
        req[0] = 1'b1; addr[0] = 16'h0040; we[0] = 1'b1; wdata[0] = d; be[0] = 8'hFF;
        #1;
        check("R8 even parity", 64'(bk_wpar[0]), 64'(exp_par(d, 1'b0)));
        check("R9 enables forwarded", 64'(bk_be[0]), 64'hFF);
        @(negedge clk);
        drop_all();
        check("R7 write done", 64'(rq_done), 64'h1);
        xfer(1, 16'h0040, 1'b0, '0, 8'hFF, rd, er, dn);
        check("R7 read data", rd, d);
        check("R7 read done", 64'(dn), 64'h1);
        check("R10 clean read", 64'(er), 64'h0);
        cfg_odd_par = 1'b1;
        @(negedge clk);
        req[2] = 1'b1; addr[2] = 16'h0048; we[2] = 1'b1; wdata[2] = d; be[2] = 8'hFF;
        #1;
        check("R8 odd parity", 64'(bk_wpar[1]), 64'(exp_par(d, 1'b1)));
        @(negedge clk);
        drop_all();
        xfer(2, 16'h0048, 1'b0, '0, 8'hFF, rd, er, dn);
        check("R10 odd readback", 64'(er), 64'h0);
        cfg_odd_par = 1'b0;
        xfer(2, 16'h0048, 1'b0, '0, 8'hFF, rd, er, dn);
        check("R10 sense mismatch", 64'(er), 64'h1);
    endtask

    task automatic t_strobe();
        logic [63:0] rd; logic er, dn;
        xfer(0, 16'h0050, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, rd, er, dn);
        xfer(0, 16'h0050, 1'b1, 64'h0, 8'h0F, rd, er, dn);
        xfer(0, 16'h0050, 1'b0, '0, 8'hFF, rd, er, dn);
        check("R9 partial write", rd, 64'hFFFF_FFFF_0000_0000);
        check("R9 parity kept", 64'(er), 64'h0);
    endtask

    task automatic t_priority();
        @(negedge clk);
        req = 3'b011; addr[0] = 16'h0060; addr[1] = 16'h0070;
        #1;
        check("R2 ls granted", 64'(rq_gnt), 64'h1);
        check("R6 if stalled", 64'(rq_stall), 64'h2);
        @(negedge clk);
        addr[1] = 16'h0078;
        #1;
        check("R4 split banks granted", 64'(rq_gnt), 64'h3);
        check("R6 no stall", 64'(rq_stall), 64'h0);
        @(negedge clk);
        req = 3'b110; addr[1] = 16'h0060; addr[2] = 16'h0070;
        #1;
        check("R3 dma granted", 64'(rq_gnt), 64'h4);
        check("R3 if stalled", 64'(rq_stall), 64'h2);
        @(negedge clk);
        req = 3'b101; addr[0] = 16'h0060; addr[2] = 16'h0070;
        #1;
        check("R2 ls over dma", 64'(rq_gnt), 64'h1);
        @(negedge clk);
        drop_all();
    endtask

    task automatic t_stream();
        int ls_n = 0, dma_n = 0, ls_st = 0, dma_st = 0, cyc = 0;
        while ((ls_n < 4 || dma_n < 4) && cyc < 20) begin
            @(negedge clk);
            req[0] = ls_n < 4;  addr[0] = 16'h0000 + 16'(8 * ls_n);  we[0] = 1'b1; be[0] = 8'hFF;
            req[2] = dma_n < 4; addr[2] = 16'h0200 + 16'(8 * dma_n); we[2] = 1'b1; be[2] = 8'hFF;
            #1;
            if (req[0]) begin if (rq_stall[0]) ls_st++;  else ls_n++;  end
            if (req[2]) begin if (rq_stall[2]) dma_st++; else dma_n++; end
            cyc++;
        end
        @(negedge clk);
        drop_all();
        check("R4 dma stalls once", 64'(dma_st), 64'd1);
        check("R4 ls never stalls", 64'(ls_st), 64'd0);
        check("R4 lockstep cycles", 64'(cyc), 64'd5);
    endtask

    task automatic t_wait();
        wt[0] = 1'b1;
        @(negedge clk);
        req[1] = 1'b1; addr[1] = 16'h0080;
        #1;
        check("R5 owner granted", 64'(rq_gnt), 64'h2);
        check("R6 owner stalled", 64'(rq_stall), 64'h2);
        @(negedge clk);
        req[0] = 1'b1; addr[0] = 16'h0090;
        #1;
        check("R5 hold against ls", 64'(rq_gnt), 64'h2);
        check("R5 ls kept off", 64'(rq_stall), 64'h3);
        @(negedge clk);
        wt[0] = 1'b0;
        #1;
        check("R5 release owner", 64'(rq_gnt), 64'h2);
        check("R6 owner completes", 64'(rq_stall), 64'h1);
        @(negedge clk);
        req[1] = 1'b0;
        check("R7 held read done", 64'(rq_done), 64'h2);
        #1;
        check("R5 ls after release", 64'(rq_gnt), 64'h1);
        @(negedge clk);
        drop_all();
    endtask

    task automatic t_errors();
        logic [63:0] rd; logic er, dn;
        cfg_odd_par = 1'b0;
        xfer(0, 16'h00A0, 1'b1, 64'h1122_3344_5566_7788, 8'hFF, rd, er, dn);
        flip[0] = 8'h04;
        xfer(0, 16'h00A0, 1'b0, '0, 8'hFF, rd, er, dn);
        flip[0] = 8'h00;
        check("R10 parity error", 64'(er), 64'h1);
        check("R10 error done", 64'(dn), 64'h1);
        err_arm[1] = 1'b1;
        xfer(2, 16'h00A8, 1'b1, 64'h5, 8'hFF, rd, er, dn);
        err_arm[1] = 1'b0;
        check("R11 bank error write", 64'(er), 64'h1);
        xfer(2, 16'h00A8, 1'b0, '0, 8'hFF, rd, er, dn);
        check("R11 no error later", 64'(er), 64'h0);
        check("R7 dma read data", rd, 64'h5);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bank_sel();
        t_rw_parity();
        t_strobe();
        t_priority();
        t_stream();
        t_wait();
        t_errors();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule